// File: doc/BRIEF.md
# Mixed-Width Opcode Instruction Decoder

This block is a purely combinational decoder for a 16-bit instruction word. It sorts each word into one of five layouts, pulls out the register indices, the branch offset and the byte immediate, and drives an enumerated operation code. It also drives a register-write enable, a per-flag update mask and a branch-condition selector. Two opcode widths share one encoding space. The upper nibble alone identifies the two byte-immediate loads and the six conditional relative branches. All remaining instructions are identified by the whole upper byte.

The block also builds the value for the two byte loads. The low-byte load sign-extends its 8-bit immediate. The high-byte load keeps the low byte of the destination's current contents, which the pipeline supplies on a separate input. A write aimed at register 0 is always dropped, because that register reads as zero. The decoder sits between instruction fetch and operand read. It holds no state.

Top module: `insn_decoder`

## Requirements
- R1: `fmt_code` gives the layout of the word: 0 for none (no operand), 1 for byte-immediate load, 2 for relative branch, 3 for unary (register A only), 4 for binary (register A and register B).
- R2: When bits 15-12 are 1000, `op_sel` is 0x30 (high-byte load). When they are 1001, `op_sel` is 0x31 (low-byte load). In both cases `reg_a` is bits 7-4 and the word requests a register write.
- R3: For the low-byte load, `imm_value` is the byte {bits 11-8, bits 3-0} with its bit 7 copied into bits 15-8.
- R4: For the high-byte load, `imm_value` holds that byte in bits 15-8 and `cur_dest_value[7:0]` in bits 7-0. For all other words `imm_value` is 0.
- R5: Bits 15-12 from 1010 to 1111 give `op_sel` 0x38 and `br_cond` 1 to 6 in that order, meaning Z=1, Z=0, L=1, L=0, G=1, G=0. Such a word makes no register write and no flag update. `br_cond` is 0 for every word that is not a branch.
- R6: For a branch, `br_offset` is bits 11-0 sign-extended to 16 bits. For any other word it is 0.
- R7: A defined long opcode (bits 15-8) appears on `op_sel` unchanged. `reg_a` is bits 7-4 for unary and binary words and 0 otherwise. `reg_b` is bits 3-0 for binary words only and 0 otherwise.
- R8: The long opcodes that write register A are 0x01-0x0B, 0x13, 0x14, 0x16, 0x18, 0x1B-0x1F and 0x21. No other long opcode writes register A.
- R9: `reg_wr_en` is never high while `reg_a` is 0, whatever the instruction.
- R10: `flag_wr_en` bit 0 is Z, bit 1 is C, bit 2 is L and bit 3 is G. Z and C are updated by 0x01-0x03, 0x07, 0x1B-0x1F and 0x21. Z alone is updated by 0x04-0x06 and 0x08-0x0B. Z, L and G are updated by 0x11. No other opcode updates a flag.
- R11: The undefined long opcodes (0x00, 0x0C, 0x0D, 0x22-0x7F) decode exactly like the no-operation opcode 0x20: `op_sel` 0x20, `fmt_code` 0, both register fields 0, no write and no flag update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_word | input | 16 | Instruction word to decode |
| cur_dest_value | input | 16 | Current contents of the register named by bits 7-4 |
| fmt_code | output | 3 | Layout class |
| op_sel | output | 6 | Enumerated operation |
| reg_a | output | 4 | Register A / destination index |
| reg_b | output | 4 | Register B index |
| reg_wr_en | output | 1 | Write register A |
| flag_wr_en | output | 4 | Flag update mask {G,L,C,Z} |
| br_cond | output | 3 | Branch condition select |
| br_offset | output | 16 | Sign-extended relative offset |
| imm_value | output | 16 | Merged byte-load result |

## Verification
Every one of the 256 upper-byte values is applied with three different low bytes: 0x00, 0x37 and 0xFE. This shows whether the short or long opcode path was taken, and whether register fields leak into layouts that have none. Low bytes with register A equal to 0 and not equal to 0 separate the register-0 guard from the plain write decode. Byte immediates with bit 7 clear and set, together with destination values that differ from them, show whether the loads sign-extend and keep the low byte. Branch offsets at 0x7FF, 0x800, 0x000 and 0xFFF place the sign-extension boundary.

// File: rtl/idec_pkg.sv
package idec_pkg;

   typedef enum logic [2:0] {
      FMT_NONE   = 3'd0,
      FMT_IMM    = 3'd1,
      FMT_BRANCH = 3'd2,
      FMT_UNARY  = 3'd3,
      FMT_BINARY = 3'd4
   } fmt_e;

   localparam logic [5:0] OP_NOP = 6'h20;
   localparam logic [5:0] OP_LDH = 6'h30;
   localparam logic [5:0] OP_LDL = 6'h31;
   localparam logic [5:0] OP_BR  = 6'h38;

   localparam int FL_Z = 0;
   localparam int FL_C = 1;
   localparam int FL_L = 2;
   localparam int FL_G = 3;
   localparam int FL_N = 4;

   typedef struct packed {
      fmt_e              fmt;
      logic [5:0]        op;
      logic              wr;
      logic [FL_N-1:0]   flags;
   } long_dec_t;

endpackage

// File: rtl/idec_long_table.sv
module idec_long_table
   import idec_pkg::*;
#(
   parameter int OPC_W = 8
) (
   input  logic [OPC_W-1:0] opc,
   output long_dec_t        dec
);

   localparam logic [FL_N-1:0] M_ZC  = (FL_N'(1) << FL_Z) | (FL_N'(1) << FL_C);
   localparam logic [FL_N-1:0] M_Z   = (FL_N'(1) << FL_Z);
   localparam logic [FL_N-1:0] M_ZLG = (FL_N'(1) << FL_Z) | (FL_N'(1) << FL_L)
                                     | (FL_N'(1) << FL_G);

   generate
      if (OPC_W != 8) begin : g_bad_w
         $error("idec_long_table: OPC_W must be 8");
      end
   endgenerate

   always_comb begin
      dec.fmt   = FMT_NONE;
      dec.op    = OP_NOP;
      dec.wr    = 1'b0;
      dec.flags = '0;
      case (opc)
         8'h01, 8'h02, 8'h03, 8'h21: begin
            dec.fmt = FMT_BINARY; dec.op = opc[5:0]; dec.wr = 1'b1; dec.flags = M_ZC;
         end
         8'h04, 8'h05, 8'h06: begin
            dec.fmt = FMT_BINARY; dec.op = opc[5:0]; dec.wr = 1'b1; dec.flags = M_Z;
         end
         8'h07: begin
            dec.fmt = FMT_UNARY; dec.op = opc[5:0]; dec.wr = 1'b1; dec.flags = M_ZC;
         end
         8'h08, 8'h09, 8'h0A, 8'h0B: begin
            dec.fmt = FMT_UNARY; dec.op = opc[5:0]; dec.wr = 1'b1; dec.flags = M_Z;
         end
         8'h0E, 8'h0F, 8'h19, 8'h1A: begin
            dec.fmt = FMT_UNARY; dec.op = opc[5:0];
         end
         8'h10, 8'h20: begin
            dec.fmt = FMT_NONE; dec.op = opc[5:0];
         end
         8'h11: begin
            dec.fmt = FMT_BINARY; dec.op = opc[5:0]; dec.flags = M_ZLG;
         end
         8'h12, 8'h15, 8'h17: begin
            dec.fmt = FMT_BINARY; dec.op = opc[5:0];
         end
         8'h13, 8'h14, 8'h16: begin
            dec.fmt = FMT_BINARY; dec.op = opc[5:0]; dec.wr = 1'b1;
         end
         8'h18: begin
            dec.fmt = FMT_UNARY; dec.op = opc[5:0]; dec.wr = 1'b1;
         end
         8'h1B, 8'h1C, 8'h1D, 8'h1E, 8'h1F: begin
            dec.fmt = FMT_UNARY; dec.op = opc[5:0]; dec.wr = 1'b1; dec.flags = M_ZC;
         end
         default: begin
            dec.fmt = FMT_NONE; dec.op = OP_NOP;
         end
      endcase
   end

   always_comb begin
      // R11
      undef_quiet_chk: assert (dec.op != OP_NOP || (dec.wr == 1'b0 && dec.flags == '0))
         else $error("no-op decode carries side effects");
      // R7
      op_echo_chk: assert (dec.op == OP_NOP || dec.op == opc[5:0])
         else $error("defined opcode not echoed");
   end

endmodule

// File: rtl/idec_imm_merge.sv
module idec_imm_merge #(
   parameter int WORD_W = 16,
   parameter int IMM_W  = 8
) (
   input  logic              load_high,
   input  logic              load_low,
   input  logic [IMM_W-1:0]  imm,
   input  logic [WORD_W-1:0] cur,
   output logic [WORD_W-1:0] value
);

   localparam int UP_W = WORD_W - IMM_W;

   generate
      if (UP_W != IMM_W) begin : g_bad_w
         $error("idec_imm_merge: WORD_W must be twice IMM_W");
      end
   endgenerate

   always_comb begin
      if (load_high)
         value = {imm, cur[IMM_W-1:0]};
      else if (load_low)
         value = {{UP_W{imm[IMM_W-1]}}, imm};
      else
         value = '0;
   end

   always_comb begin
      // R3
      low_sext_chk: assert (!load_low || value[WORD_W-1:IMM_W] == '0 ||
                            value[WORD_W-1:IMM_W] == '1)
         else $error("low-byte load upper bits not uniform");
      // R4
      high_keep_chk: assert (!load_high || value[IMM_W-1:0] == cur[IMM_W-1:0])
         else $error("high-byte load lost low byte");
      // R4
      idle_zero_chk: assert (load_high || load_low || value == '0)
         else $error("immediate value leaked");
   end

endmodule

// File: rtl/idec_offset_ext.sv
module idec_offset_ext #(
   parameter int IN_W   = 12,
   parameter int OUT_W  = 16,
   parameter bit SIGNED = 1'b1
) (
   input  logic             en,
   input  logic [IN_W-1:0]  raw,
   output logic [OUT_W-1:0] ext
);

   localparam int PAD_W = OUT_W - IN_W;

   generate
      if (PAD_W < 1) begin : g_bad_w
         $error("idec_offset_ext: OUT_W must exceed IN_W");
      end
      if (SIGNED) begin : g_sext
         assign ext = en ? {{PAD_W{raw[IN_W-1]}}, raw} : '0;
         always_comb begin
            // R6
            off_sign_chk: assert (!en || ext[OUT_W-1] == raw[IN_W-1])
               else $error("offset sign lost");
         end
      end else begin : g_zext
         assign ext = en ? {{PAD_W{1'b0}}, raw} : '0;
      end
   endgenerate

endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
   import idec_pkg::*;
#(
   parameter int WORD_W         = 16,
   parameter int REG_W          = 4,
   parameter int OFF_W          = 12,
   parameter bit OFFSET_SIGNED  = 1'b1,
   parameter bit GUARD_ZERO_REG = 1'b1
) (
   input  logic [WORD_W-1:0] instr_word,
   input  logic [WORD_W-1:0] cur_dest_value,
   output logic [2:0]        fmt_code,
   output logic [5:0]        op_sel,
   output logic [REG_W-1:0]  reg_a,
   output logic [REG_W-1:0]  reg_b,
   output logic              reg_wr_en,
   output logic [FL_N-1:0]   flag_wr_en,
   output logic [2:0]        br_cond,
   output logic [WORD_W-1:0] br_offset,
   output logic [WORD_W-1:0] imm_value
);

   localparam int TOP_W  = 4;
   localparam int OPC_W  = 8;
   localparam int IMM_W  = WORD_W / 2;
   localparam int RA_LO  = REG_W;
   localparam logic [TOP_W-1:0] TOP_LDH = 4'h8;
   localparam logic [TOP_W-1:0] TOP_LDL = 4'h9;
   localparam logic [TOP_W-1:0] TOP_BR0 = 4'hA;

   generate
      if (WORD_W != 16) begin : g_bad_word
         $error("insn_decoder: WORD_W must be 16");
      end
      if (REG_W != 4) begin : g_bad_reg
         $error("insn_decoder: REG_W must be 4");
      end
      if (OFF_W != WORD_W - TOP_W) begin : g_bad_off
         $error("insn_decoder: OFF_W must fill the word below the short opcode");
      end
   endgenerate

   logic [TOP_W-1:0] top4;
   logic             is_ld_short, is_br_short;
   logic             ld_high, ld_low;
   logic             wr_raw;
   long_dec_t        ldec;
   logic [IMM_W-1:0] imm8;
   logic [REG_W-1:0] ra_field, rb_field;

   assign top4        = instr_word[WORD_W-1 -: TOP_W];
   assign ld_high     = (top4 == TOP_LDH);
   assign ld_low      = (top4 == TOP_LDL);
   assign is_ld_short = ld_high | ld_low;
   assign is_br_short = (top4 >= TOP_BR0);
   assign ra_field    = instr_word[RA_LO +: REG_W];
   assign rb_field    = instr_word[REG_W-1:0];
   assign imm8        = {instr_word[WORD_W-TOP_W-1 -: TOP_W], instr_word[TOP_W-1:0]};

   idec_long_table #(.OPC_W(OPC_W)) u_table (
      .opc (instr_word[WORD_W-1 -: OPC_W]),
      .dec (ldec)
   );

   idec_imm_merge #(.WORD_W(WORD_W), .IMM_W(IMM_W)) u_merge (
      .load_high (ld_high),
      .load_low  (ld_low),
      .imm       (imm8),
      .cur       (cur_dest_value),
      .value     (imm_value)
   );

   idec_offset_ext #(.IN_W(OFF_W), .OUT_W(WORD_W), .SIGNED(OFFSET_SIGNED)) u_off (
      .en  (is_br_short),
      .raw (instr_word[OFF_W-1:0]),
      .ext (br_offset)
   );

   always_comb begin
      fmt_code   = FMT_NONE;
      op_sel     = OP_NOP;
      reg_a      = '0;
      reg_b      = '0;
      wr_raw     = 1'b0;
      flag_wr_en = '0;
      br_cond    = '0;
      if (is_ld_short) begin
         fmt_code = FMT_IMM;
         op_sel   = ld_low ? OP_LDL : OP_LDH;
         reg_a    = ra_field;
         wr_raw   = 1'b1;
      end else if (is_br_short) begin
         fmt_code = FMT_BRANCH;
         op_sel   = OP_BR;
         br_cond  = 3'(top4 - TOP_BR0) + 3'd1;
      end else begin
         fmt_code   = ldec.fmt;
         op_sel     = ldec.op;
         wr_raw     = ldec.wr;
         flag_wr_en = ldec.flags;
         if (ldec.fmt == FMT_UNARY || ldec.fmt == FMT_BINARY)
            reg_a = ra_field;
         if (ldec.fmt == FMT_BINARY)
            reg_b = rb_field;
      end
   end

   generate
      if (GUARD_ZERO_REG) begin : g_guard
         assign reg_wr_en = wr_raw & (reg_a != '0);
      end else begin : g_noguard
         assign reg_wr_en = wr_raw;
      end
   endgenerate

   always_comb begin
      // R9
      zero_reg_wr_chk: assert (!GUARD_ZERO_REG || !reg_wr_en || reg_a != '0)
         else $error("write to register 0");
      // R5
      br_cond_fmt_chk: assert ((br_cond != 3'd0) == (fmt_code == FMT_BRANCH))
         else $error("branch condition outside branch layout");
      // R5
      br_quiet_chk: assert (fmt_code != FMT_BRANCH || (!reg_wr_en && flag_wr_en == '0))
         else $error("branch with side effects");
      // R7
      rb_only_binary_chk: assert (reg_b == '0 || fmt_code == FMT_BINARY)
         else $error("register B outside binary layout");
   end

endmodule

// File: tb/test_insn_decoder.sv
module test_insn_decoder;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] instr_word = 16'h2000;
   logic [15:0] cur_dest_value = 16'h0000;
   logic [2:0]  fmt_code;
   logic [5:0]  op_sel;
   logic [3:0]  reg_a, reg_b;
   logic        reg_wr_en;
   logic [3:0]  flag_wr_en;
   logic [2:0]  br_cond;
   logic [15:0] br_offset, imm_value;

   always #5 clk = ~clk;

   insn_decoder i_insn_decoder (
      .instr_word     (instr_word),
      .cur_dest_value (cur_dest_value),
      .fmt_code       (fmt_code),
      .op_sel         (op_sel),
      .reg_a          (reg_a),
      .reg_b          (reg_b),
      .reg_wr_en      (reg_wr_en),
      .flag_wr_en     (flag_wr_en),
      .br_cond        (br_cond),
      .br_offset      (br_offset),
      .imm_value      (imm_value)
   );

   typedef struct packed {
      logic [2:0]  fmt;
      logic [5:0]  op;
      logic [3:0]  ra;
      logic [3:0]  rb;
      logic        we;
      logic [3:0]  fl;
      logic [2:0]  cond;
      logic [15:0] off;
      logic [15:0] imm;
   } obs_t;

   typedef struct {
      obs_t  exp;
      string tag;
   } item_t;

   item_t q[$];
   int    n_cmp = 0;
   int    n_bad = 0;
   bit    driving_done = 1'b0;

   // Reference model written from the requirement text
   function automatic obs_t model(input logic [15:0] w, input logic [15:0] d,
                                  output string tag);
      obs_t e;
      logic [7:0] hb;
      logic [7:0] bt;
      e  = '0;
      hb = w[15:8];
      bt = {w[11:8], w[3:0]};
      e.op = 6'h20;
      tag = "R1";
      if (w[15:12] == 4'b1000) begin                    // R2 R4
         e.fmt = 3'd1; e.op = 6'h30; e.ra = w[7:4];
         e.we = (w[7:4] != 0); e.imm = {bt, d[7:0]}; tag = "R4";
      end else if (w[15:12] == 4'b1001) begin           // R2 R3
         e.fmt = 3'd1; e.op = 6'h31; e.ra = w[7:4];
         e.we = (w[7:4] != 0); e.imm = {{8{bt[7]}}, bt}; tag = "R3";
      end else if (w[15] == 1'b1) begin                 // R5 R6
         e.fmt = 3'd2; e.op = 6'h38;
         e.cond = 3'(w[15:12] - 4'd9);
         e.off = {{4{w[11]}}, w[11:0]}; tag = "R5";
      end else begin
         bit bin, un, wr;
         bin = hb inside {8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h21,
                          8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16, 8'h17};
         un  = hb inside {[8'h07:8'h0B], 8'h0E, 8'h0F, [8'h18:8'h1F]};
         wr  = hb inside {[8'h01:8'h0B], 8'h13, 8'h14, 8'h16, 8'h18,
                          [8'h1B:8'h1F], 8'h21};
         if (bin || un || hb == 8'h10 || hb == 8'h20) begin
            e.op  = hb[5:0];
            e.fmt = bin ? 3'd4 : (un ? 3'd3 : 3'd0);
            e.ra  = (bin || un) ? w[7:4] : 4'h0;
            e.rb  = bin ? w[3:0] : 4'h0;
            e.we  = wr && (w[7:4] != 0);
            if (hb inside {8'h01, 8'h02, 8'h03, 8'h07, [8'h1B:8'h1F], 8'h21})
               e.fl = 4'b0011;
            else if (hb inside {[8'h04:8'h06], [8'h08:8'h0B]})
               e.fl = 4'b0001;
            else if (hb == 8'h11)
               e.fl = 4'b1101;
            tag = wr ? "R8" : "R7";
            if (e.fl != 0) tag = "R10";
         end else begin
            tag = "R11";                                 // undefined -> no-op
         end
      end
      return e;
   endfunction

   function automatic obs_t sample();
      return '{fmt_code, op_sel, reg_a, reg_b, reg_wr_en, flag_wr_en,
               br_cond, br_offset, imm_value};
   endfunction

   // Driver: apply a word at a rising edge and push its expected result
   task automatic drive(input logic [15:0] w, input logic [15:0] d,
                        input string tag_override = "");
      item_t it;
      string t;
      @(posedge clk);
      instr_word     = w;
      cur_dest_value = d;
      it.exp = model(w, d, t);
      it.tag = (tag_override != "") ? tag_override : t;
      q.push_back(it);
   endtask

   // Driver for a fully hand-written expectation
   task automatic drive_exp(input logic [15:0] w, input logic [15:0] d,
                            input obs_t e, input string tag);
      item_t it;
      @(posedge clk);
      instr_word     = w;
      cur_dest_value = d;
      it.exp = e;
      it.tag = tag;
      q.push_back(it);
   endtask

   // Monitor: compare at the falling edge, away from the driving edge
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            item_t it;
            obs_t  a;
            it = q.pop_front();
            a  = sample();
            n_cmp++;
            if (a !== it.exp) begin
               n_bad++;
               $display("FAIL %s word=%h actual=%h expected=%h",
                        it.tag, instr_word, a, it.exp);
            end
         end
      end
   end

   initial begin
      #2000000;
      if (!driving_done) begin
         n_bad++;
         $display("FAIL watchdog run did not complete actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      obs_t e;
      // Reset phase: the idle no-op word must decode quietly (R11)
      repeat (3) @(posedge clk);
      rst = 1'b0;
      e = '0; e.op = 6'h20;
      drive_exp(16'h2000, 16'h0000, e, "R11");

      // R3: low-byte load, negative byte 0x9C, into r5
      e = '0; e.fmt = 3'd1; e.op = 6'h31; e.ra = 4'h5; e.we = 1'b1; e.imm = 16'hFF9C;
      drive_exp(16'h995C, 16'h1234, e, "R3");
      // R3: positive byte 0x7F
      e.imm = 16'h007F;
      drive_exp(16'h975F, 16'hABCD, e, "R3");
      // R4: high-byte load keeps low byte of destination
      e = '0; e.fmt = 3'd1; e.op = 6'h30; e.ra = 4'h3; e.we = 1'b1; e.imm = 16'hA5CD;
      drive_exp(16'h8A35, 16'h12CD, e, "R4");
      // R9: load aimed at register 0 has no write
      e = '0; e.fmt = 3'd1; e.op = 6'h31; e.ra = 4'h0; e.we = 1'b0; e.imm = 16'hFF80;
      drive_exp(16'h9800, 16'h0000, e, "R9");
      // R9: ADD r0,r1 no write, flags still updated
      e = '0; e.fmt = 3'd4; e.op = 6'h21; e.rb = 4'h1; e.fl = 4'b0011;
      drive_exp(16'h2101, 16'h0000, e, "R9");
      // R6: offset sign boundaries
      e = '0; e.fmt = 3'd2; e.op = 6'h38; e.cond = 3'd1; e.off = 16'h07FF;
      drive_exp(16'hA7FF, 16'h0000, e, "R6");
      e.off = 16'hF800;
      drive_exp(16'hA800, 16'h0000, e, "R6");
      e.cond = 3'd6; e.off = 16'hFFFF;
      drive_exp(16'hFFFF, 16'h0000, e, "R6");
      e.cond = 3'd4; e.off = 16'h0000;
      drive_exp(16'hD000, 16'hFFFF, e, "R5");
      // R10: compare updates Z, L, G
      e = '0; e.fmt = 3'd4; e.op = 6'h11; e.ra = 4'h2; e.rb = 4'h3; e.fl = 4'b1101;
      drive_exp(16'h1123, 16'h0000, e, "R10");
      // R8: POP r7 writes, PUSH r7 does not
      e = '0; e.fmt = 3'd3; e.op = 6'h18; e.ra = 4'h7; e.we = 1'b1;
      drive_exp(16'h1870, 16'h0000, e, "R8");
      e.op = 6'h19; e.we = 1'b0;
      drive_exp(16'h1970, 16'h0000, e, "R8");
      // R11: undefined opcodes 0x0C and 0x7F ignore their fields
      e = '0; e.op = 6'h20;
      drive_exp(16'h0CFF, 16'hFFFF, e, "R11");
      drive_exp(16'h7F5A, 16'hFFFF, e, "R11");

      // R1 R2 R5 R7 R8 R10 R11: sweep every upper byte with three low bytes
      for (int hb = 0; hb < 256; hb++) begin
         drive({8'(hb), 8'h00}, 16'h5A3C);
         drive({8'(hb), 8'h37}, 16'hC3A5);
         drive({8'(hb), 8'hFE}, 16'h0081);
      end

      repeat (3) @(posedge clk);
      driving_done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule